// File: doc/BRIEF.md
# Spare Steering Network for a Banded MAC Array

This block sits between the logical operand streams of a small systolic multiply-accumulate array and its physical processing elements. The array is split into `NPART` independent partitions. Each partition holds one band of `SHARE` adjacent lines, and each line has `NPOS` elements. The band has one spare element, placed after the last position and shared by all lines of the band. The same block serves row bands and column bands; only the orientation of the wiring differs.

A repair map is loaded for each partition while a configuration strobe is high. The map names a faulty line and a faulty position. In the repaired line, every logical role from the faulty position onward moves one physical place toward the spare. The faulty element is bypassed and the spare takes the last role. The other lines of the band stay unchanged.

The operands the block sends to the physical elements are combinational. The results it gathers back into logical order are registered once. Between loads the selects are frozen, so no steering path changes during a computation.

Top module: `spare_steer_net`

## Requirements
- R1: While reset is asserted, every partition has no active repair, `lg_res` is all zero and every spare drive slot is zero.
- R2: With no active repair in a partition, physical element j of line l receives logical role j of line l in the same cycle, and logical result j is physical result j of line l one clock later.
- R3: With an active repair at line L, position k, physical element j of line L receives role j for j < k and role j-1 for j > k. The spare receives role NPOS-1 of line L.
- R4: With an active repair at line L, position k, logical result p of line L is taken from physical element p for p < k, from element p+1 for k <= p < NPOS-1, and from the spare for p = NPOS-1, one clock later.
- R5: The drive of the bypassed element is zero while its repair is active.
- R6: Lines of a band other than the repaired line pass their streams straight through, as in R2.
- R7: While a partition has no active repair, its spare drive is zero.
- R8: The repair map is captured only at a rising clock edge where `cfg_load` is high, and it governs steering from the following cycle. Changes on `cfg_valid`, `cfg_line` or `cfg_pos` at any other time have no effect.
- R9: Each partition's steering depends only on its own map fields and streams.
- R10: A load with the valid bit clear, a position of NPOS or more, or a line of SHARE or more leaves that partition with no active repair. This clears any earlier repair.
- R11: Vector layout. Partition p, line l, position j takes data bits at slot index `(p*SHARE+l)*NPOS+j` in `lg_in`/`lg_res`, and at slot `p*(SHARE*NPOS+1)+l*NPOS+j` in `ph_drv`/`ph_res`. The spare of partition p takes slot `p*(SHARE*NPOS+1)+SHARE*NPOS`. Map fields for partition p take `cfg_line[p*LW +: LW]` and `cfg_pos[p*PW +: PW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Strobe; the map fields are captured at a rising edge while high |
| cfg_valid | input | NPART | Repair enable per partition |
| cfg_line | input | NPART*LW | Faulty line per partition |
| cfg_pos | input | NPART*PW | Faulty position per partition |
| lg_in | input | NPART*SHARE*NPOS*DW | Logical operand streams |
| ph_res | input | NPART*(SHARE*NPOS+1)*DW | Results coming back from physical elements and spares |
| ph_drv | output | NPART*(SHARE*NPOS+1)*DW | Operands steered to physical elements and spares |
| lg_res | output | NPART*SHARE*NPOS*DW | Results in logical order, registered |

## Verification
Operand steering onto `ph_drv` settles in the same cycle as `lg_in`. The bench therefore compares it against an independently built placement a short delay after each negative-edge drive. Logical results appear on `lg_res` at the rising edge after the physical results are present. Each drive pushes its expected item into a scoreboard queue, and a monitor pops and compares that item just after that next edge. A map load takes effect one edge after the strobe, so data is applied only after the strobe has been dropped. The bench's element model applies a fixed function and corrupts the injected faulty element. Correct repair at every single-fault position of every line therefore shows up as fault-free logical results.

// File: rtl/spare_steer_pkg.sv
package spare_steer_pkg;

  // Logical role that feeds physical element j when position k of the
  // line is bypassed; -1 marks the bypassed element itself.
  function automatic int role_of_phys(int j, int k, logic rep);
    if (!rep || j < k) return j;
    if (j == k) return -1;
    return j - 1;
  endfunction

  // Physical element that carries logical role r; a return value equal
  // to the line length selects the shared spare.
  function automatic int phys_of_role(int r, int k, logic rep);
    if (!rep || r < k) return r;
    return r + 1;
  endfunction

endpackage

// File: rtl/spare_map_reg.sv
module spare_map_reg #(
  parameter int SHARE = 2,
  parameter int NPOS  = 4,
  parameter int LW    = 1,
  parameter int PW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             vld_in,
  input  logic [LW-1:0]    line_in,
  input  logic [PW-1:0]    pos_in,
  output logic             rep_vld,
  output logic [SHARE-1:0] line_oh,
  output logic [PW-1:0]    rep_pos
);

  logic [LW-1:0] line_q;
  logic          accept;

  assign accept = vld_in && (int'(pos_in) < NPOS) && (int'(line_in) < SHARE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_vld <= 1'b0;
      line_q  <= '0;
      rep_pos <= '0;
    end else if (load) begin
      rep_vld <= accept;
      line_q  <= accept ? line_in : '0;
      rep_pos <= accept ? pos_in  : '0;
    end
  end

  for (genvar l = 0; l < SHARE; l++) begin : g_dec
    assign line_oh[l] = rep_vld && (line_q == LW'(l));
  end

endmodule

// File: rtl/spare_line_mux.sv
module spare_line_mux
  import spare_steer_pkg::*;
#(
  parameter int NPOS = 4,
  parameter int DW   = 8,
  parameter int PW   = 3
) (
  input  logic               rep,
  input  logic [PW-1:0]      k,
  input  logic [NPOS*DW-1:0] lg_in,
  input  logic [NPOS*DW-1:0] ph_res,
  input  logic [DW-1:0]      spare_res,
  output logic [NPOS*DW-1:0] ph_drv,
  output logic [DW-1:0]      spare_drv,
  output logic [NPOS*DW-1:0] lg_out
);

  always_comb begin
    ph_drv = '0;
    for (int j = 0; j < NPOS; j++) begin
      int r;
      r = role_of_phys(j, int'(k), rep);
      if (r >= 0) ph_drv[j*DW +: DW] = lg_in[r*DW +: DW];
    end
  end

  always_comb begin
    lg_out = '0;
    for (int r = 0; r < NPOS; r++) begin
      int p;
      p = phys_of_role(r, int'(k), rep);
      if (p >= NPOS) lg_out[r*DW +: DW] = spare_res;
      else           lg_out[r*DW +: DW] = ph_res[p*DW +: DW];
    end
  end

  assign spare_drv = rep ? lg_in[(NPOS-1)*DW +: DW] : '0;

endmodule

// File: rtl/spare_band.sv
module spare_band #(
  parameter int SHARE = 2,
  parameter int NPOS  = 4,
  parameter int DW    = 8,
  parameter int LW    = 1,
  parameter int PW    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     vld_in,
  input  logic [LW-1:0]            line_in,
  input  logic [PW-1:0]            pos_in,
  input  logic [SHARE*NPOS*DW-1:0] lg_in,
  input  logic [(SHARE*NPOS+1)*DW-1:0] ph_res,
  output logic [(SHARE*NPOS+1)*DW-1:0] ph_drv,
  output logic [SHARE*NPOS*DW-1:0] lg_out,
  output logic                     rep_vld,
  output logic [SHARE-1:0]         line_oh,
  output logic [PW-1:0]            rep_pos
);

  localparam int LINEW = NPOS * DW;
  localparam int NLG   = SHARE * NPOS;

  logic [SHARE*LINEW-1:0] line_drv;
  logic [SHARE*DW-1:0]    spare_part;
  logic [DW-1:0]          spare_drv;
  logic [DW-1:0]          spare_res;

  spare_map_reg #(.SHARE(SHARE), .NPOS(NPOS), .LW(LW), .PW(PW)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .vld_in  (vld_in),
    .line_in (line_in),
    .pos_in  (pos_in),
    .rep_vld (rep_vld),
    .line_oh (line_oh),
    .rep_pos (rep_pos)
  );

  assign spare_res = ph_res[NLG*DW +: DW];

  for (genvar l = 0; l < SHARE; l++) begin : g_line
    spare_line_mux #(.NPOS(NPOS), .DW(DW), .PW(PW)) u_mux (
      .rep       (line_oh[l]),
      .k         (rep_pos),
      .lg_in     (lg_in[l*LINEW +: LINEW]),
      .ph_res    (ph_res[l*LINEW +: LINEW]),
      .spare_res (spare_res),
      .ph_drv    (line_drv[l*LINEW +: LINEW]),
      .spare_drv (spare_part[l*DW +: DW]),
      .lg_out    (lg_out[l*LINEW +: LINEW])
    );
  end

  // At most one line is selected, so the spare operand is an OR of the
  // per-line contributions, each zero unless that line is repaired.
  always_comb begin
    spare_drv = '0;
    for (int l = 0; l < SHARE; l++) spare_drv = spare_drv | spare_part[l*DW +: DW];
  end

  assign ph_drv = {spare_drv, line_drv};

endmodule

// File: rtl/spare_steer_net.sv
module spare_steer_net #(
  parameter int NPART = 2,
  parameter int SHARE = 2,
  parameter int NPOS  = 4,
  parameter int DW    = 8,
  localparam int LW   = $clog2(SHARE > 1 ? SHARE : 2),
  localparam int PW   = $clog2(NPOS + 1),
  localparam int NLG  = SHARE * NPOS,
  localparam int EL   = NLG + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic [NPART-1:0]        cfg_valid,
  input  logic [NPART*LW-1:0]     cfg_line,
  input  logic [NPART*PW-1:0]     cfg_pos,
  input  logic [NPART*NLG*DW-1:0] lg_in,
  input  logic [NPART*EL*DW-1:0]  ph_res,
  output logic [NPART*EL*DW-1:0]  ph_drv,
  output logic [NPART*NLG*DW-1:0] lg_res
);

  logic [NPART*NLG*DW-1:0] lg_comb;
  logic [NPART-1:0]        part_rep_vld;
  logic [NPART*SHARE-1:0]  part_line_oh;
  logic [NPART*PW-1:0]     part_rep_pos;

  for (genvar p = 0; p < NPART; p++) begin : g_part
    spare_band #(.SHARE(SHARE), .NPOS(NPOS), .DW(DW), .LW(LW), .PW(PW)) u_band (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cfg_load),
      .vld_in  (cfg_valid[p]),
      .line_in (cfg_line[p*LW +: LW]),
      .pos_in  (cfg_pos[p*PW +: PW]),
      .lg_in   (lg_in[p*NLG*DW +: NLG*DW]),
      .ph_res  (ph_res[p*EL*DW +: EL*DW]),
      .ph_drv  (ph_drv[p*EL*DW +: EL*DW]),
      .lg_out  (lg_comb[p*NLG*DW +: NLG*DW]),
      .rep_vld (part_rep_vld[p]),
      .line_oh (part_line_oh[p*SHARE +: SHARE]),
      .rep_pos (part_rep_pos[p*PW +: PW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lg_res <= '0;
    else        lg_res <= lg_comb;
  end

endmodule

// File: rtl/spare_steer_chk.sv
module spare_steer_chk #(
  parameter int NPART = 2,
  parameter int SHARE = 2,
  parameter int NPOS  = 4,
  parameter int DW    = 8,
  parameter int PW    = 3,
  localparam int NLG  = SHARE * NPOS,
  localparam int EL   = NLG + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_load,
  input logic [NPART*NLG*DW-1:0] lg_in,
  input logic [NPART*EL*DW-1:0]  ph_res,
  input logic [NPART*EL*DW-1:0]  ph_drv,
  input logic [NPART*NLG*DW-1:0] lg_res,
  input logic [NPART-1:0]        part_rep_vld,
  input logic [NPART*SHARE-1:0]  part_line_oh,
  input logic [NPART*PW-1:0]     part_rep_pos
);

  for (genvar p = 0; p < NPART; p++) begin : g_p
    logic [DW-1:0] bypass_drv;
    logic [DW-1:0] last_role;
    logic [DW-1:0] spare_drv;

    assign spare_drv = ph_drv[(p*EL + NLG)*DW +: DW];

    always_comb begin
      int sel;
      sel = 0;
      for (int l = 0; l < SHARE; l++) if (part_line_oh[p*SHARE + l]) sel = l;
      bypass_drv = '0;
      last_role  = '0;
      if (part_rep_vld[p]) begin
        bypass_drv = ph_drv[(p*EL + sel*NPOS + int'(part_rep_pos[p*PW +: PW]))*DW +: DW];
        last_role  = lg_in[((p*SHARE + sel)*NPOS + NPOS-1)*DW +: DW];
      end
    end

    AST_SPARE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !part_rep_vld[p] |-> spare_drv == '0); // R7

    AST_SPARE_TAKES_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      part_rep_vld[p] |-> spare_drv == last_role); // R3

    AST_BYPASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      part_rep_vld[p] |-> bypass_drv == '0); // R5

    AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(part_rep_vld[p]) && $stable(part_rep_pos[p*PW +: PW])
                    && $stable(part_line_oh[p*SHARE +: SHARE])); // R8

    AST_STRAIGHT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !part_rep_vld[p] |=> lg_res[p*NLG*DW +: NLG*DW] == $past(ph_res[p*EL*DW +: NLG*DW])); // R2
  end

  AST_ONE_LINE_PER_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(part_line_oh[SHARE-1:0])); // R3

endmodule

bind spare_steer_net spare_steer_chk #(
  .NPART(NPART), .SHARE(SHARE), .NPOS(NPOS), .DW(DW), .PW(PW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_load     (cfg_load),
  .lg_in        (lg_in),
  .ph_res       (ph_res),
  .ph_drv       (ph_drv),
  .lg_res       (lg_res),
  .part_rep_vld (part_rep_vld),
  .part_line_oh (part_line_oh),
  .part_rep_pos (part_rep_pos)
);

// File: tb/spare_steer_net_bench.sv
module spare_steer_net_bench;
  localparam int NPART = 2, SHARE = 2, NPOS = 4, DW = 8;
  localparam int LW = 1, PW = 3, NLG = SHARE*NPOS, EL = NLG + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rst_n;
  logic                    cfg_load;
  logic [NPART-1:0]        cfg_valid;
  logic [NPART*LW-1:0]     cfg_line;
  logic [NPART*PW-1:0]     cfg_pos;
  logic [NPART*NLG*DW-1:0] lg_in;
  logic [NPART*EL*DW-1:0]  ph_res;
  logic [NPART*EL*DW-1:0]  ph_drv;
  logic [NPART*NLG*DW-1:0] lg_res;

  spare_steer_net #(.NPART(NPART), .SHARE(SHARE), .NPOS(NPOS), .DW(DW)) u_spare_steer_net (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_valid(cfg_valid),
    .cfg_line(cfg_line), .cfg_pos(cfg_pos), .lg_in(lg_in), .ph_res(ph_res),
    .ph_drv(ph_drv), .lg_res(lg_res)
  );

  logic [DW-1:0]        li [NPART][SHARE][NPOS];
  logic [NPART*EL-1:0]  bad;
  int                   mv [NPART];
  int                   ml [NPART];
  int                   mk [NPART];
  int                   n_chk = 0;
  int                   n_err = 0;

  typedef struct { logic [NPART*NLG*DW-1:0] v; string tag; } item_t;
  item_t sb[$];

  function automatic logic [DW-1:0] elem_fn(logic [DW-1:0] x);
    return x * 8'd3 + 8'd7;
  endfunction

  always_comb begin
    for (int p = 0; p < NPART; p++)
      for (int l = 0; l < SHARE; l++)
        for (int r = 0; r < NPOS; r++)
          lg_in[((p*SHARE + l)*NPOS + r)*DW +: DW] = li[p][l][r];
  end

  // Element model: a fixed function; an injected fault corrupts the result.
  always_comb begin
    for (int s = 0; s < NPART*EL; s++)
      ph_res[s*DW +: DW] = bad[s] ? (ph_drv[s*DW +: DW] ^ 8'hEE) : elem_fn(ph_drv[s*DW +: DW]);
  end

  function automatic logic [NPART*EL*DW-1:0] exp_drive();
    logic [NPART*EL*DW-1:0] v;
    v = '0;
    for (int p = 0; p < NPART; p++)
      for (int l = 0; l < SHARE; l++)
        for (int r = 0; r < NPOS; r++) begin
          int ph, slot;
          ph   = (mv[p] != 0 && l == ml[p] && r >= mk[p]) ? r + 1 : r;
          slot = (ph == NPOS) ? p*EL + NLG : p*EL + l*NPOS + ph;
          v[slot*DW +: DW] = li[p][l][r];
        end
    return v;
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Monitor: each result is due on the edge after its drive.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, 256'(lg_res), 256'(it.v));
    end
  end

  task automatic apply(int seed, string tag);
    item_t it;
    @(negedge clk);
    for (int p = 0; p < NPART; p++)
      for (int l = 0; l < SHARE; l++)
        for (int r = 0; r < NPOS; r++)
          li[p][l][r] = DW'(seed*37 + p*71 + l*13 + r*5 + (seed >> 1)*r + 1);
    #1;
    check({tag, " drive"}, 256'(ph_drv), 256'(exp_drive()));
    it.v = '0;
    for (int p = 0; p < NPART; p++)
      for (int l = 0; l < SHARE; l++)
        for (int r = 0; r < NPOS; r++)
          it.v[((p*SHARE + l)*NPOS + r)*DW +: DW] = elem_fn(li[p][l][r]);
    it.tag = {tag, " result"};
    sb.push_back(it);
  endtask

  task automatic configure(int v0, int l0, int k0, int v1, int l1, int k1, bit inject);
    int vv[NPART]; int ll[NPART]; int kk[NPART];
    vv[0] = v0; ll[0] = l0; kk[0] = k0; vv[1] = v1; ll[1] = l1; kk[1] = k1;
    @(negedge clk);
    bad = '0;
    for (int p = 0; p < NPART; p++) begin
      cfg_valid[p]           = vv[p][0];
      cfg_line[p*LW +: LW]   = LW'(ll[p]);
      cfg_pos[p*PW +: PW]    = PW'(kk[p]);
      mv[p] = (vv[p] != 0 && kk[p] < NPOS && ll[p] < SHARE) ? 1 : 0;
      ml[p] = ll[p]; mk[p] = kk[p];
      if (inject && mv[p] != 0) bad[p*EL + ll[p]*NPOS + kk[p]] = 1'b1;
    end
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_valid = '0; cfg_line = '0; cfg_pos = '0; bad = '0;
    for (int p = 0; p < NPART; p++) begin
      mv[p] = 0; ml[p] = 0; mk[p] = 0;
      for (int l = 0; l < SHARE; l++)
        for (int r = 0; r < NPOS; r++) li[p][l][r] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 lg_res in reset", 256'(lg_res), 256'(0));
    check("R1 spare0 drive in reset", 256'(ph_drv[NLG*DW +: DW]), 256'(0));
    check("R1 spare1 drive in reset", 256'(ph_drv[(EL+NLG)*DW +: DW]), 256'(0));
    rst_n = 1'b1;

    // No repair: straight paths and idle spares.
    for (int s = 0; s < 3; s++) apply(s, "R2/R7/R11 straight");

    // Every single-fault position in every line, both partitions at once.
    for (int l = 0; l < SHARE; l++)
      for (int k = 0; k < NPOS; k++) begin
        configure(1, l, k, 1, SHARE-1-l, NPOS-1-k, 1'b1);
        apply(l*8 + k + 5,  "R3/R4/R5/R6/R9 shift");
        apply(l*8 + k + 40, "R3/R4/R5/R6/R9 shift");
      end

    // Map fields move without the strobe: steering must not change.
    configure(1, 0, 2, 1, 1, 1, 1'b1);
    @(negedge clk);
    cfg_valid = 2'b11; cfg_line = 2'b01; cfg_pos = {3'd3, 3'd0};
    apply(77, "R8 no strobe");
    apply(78, "R8 no strobe");

    // Rejected loads clear repairs.
    configure(1, 0, NPOS, 0, 1, 2, 1'b0);
    apply(90, "R10 rejected map");
    apply(91, "R10 rejected map");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule